// File: doc/BRIEF.md
# 8-Bit Accumulator ALU with Five Status Flags

This block is the arithmetic and logic stage of a small accumulator-style datapath. Each clock in which `op_valid` is high, it takes the accumulator value and a second operand, applies the operation selected by `op_code`, and stores the outcome in a result register and a five-bit flag register. Operations that chain on earlier results (add with carry, subtract with borrow, rotates through carry and decimal adjust) read the carry and auxiliary-carry bits from that flag register. There is no separate carry-in pin, so a chain of operations needs no outside help.

The operation set covers binary add and subtract in plain and chained forms, increment and decrement, the three bitwise operations, a compare that only touches flags, four single-step rotates, and a decimal-adjust step that repairs a byte after two packed-BCD digits pairs were added. Each operation has its own rule for which flags it changes. Instruction fetch, register selection and memory access are left to the surrounding datapath. The datapath feeds `result_q` back as the next accumulator value.

Top module: `acc_alu`

## Requirements
- R1: After a clock with `rst_n` low, `result_q` is 00h and `flags_q` is 00000b. The flag bit positions are: bit0 carry (C), bit1 parity (P), bit2 auxiliary carry (AC), bit3 zero (Z), bit4 sign (S).
- R2: Add (`op_code` 0) writes (A+B) mod 256. Add-with-carry (1) writes (A+B+C) mod 256. For both, C is set when the 9-bit sum exceeds FFh, and AC is set when the sum of the low nibbles (plus C for code 1) exceeds Fh.
- R3: Subtract (2) writes (A−B) mod 256. Subtract-with-borrow (3) writes (A−B−C) mod 256. For both, C is set when a borrow leaves bit 7, and AC is set when a borrow leaves bit 3.
- R4: Every operation that writes the result, except the rotates, sets Z when the new result is 00h, copies result bit 7 into S, and sets P when the result has an even number of ones.
- R5: Increment (4) writes A+1 and decrement (5) writes A−1, both mod 256. Both update Z, S, P and AC (AC on a nibble carry or borrow) and leave C unchanged.
- R6: AND (6), OR (7) and XOR (8) write the bitwise result and clear both C and AC.
- R7: Compare (9) leaves `result_q` unchanged and sets the flags as subtraction of B from A would. This gives C=0,Z=0 for A>B, C=1,Z=0 for A<B and C=0,Z=1 for A=B.
- R8: Rotate left (10) and rotate right (11) turn A by one bit, with the bit leaving one end going to the other end and into C. S, Z, AC and P are unchanged.
- R9: Rotate left through carry (12) and rotate right through carry (13) shift A by one bit. The old C fills the vacated bit and the bit shifted out becomes the new C. S, Z, AC and P are unchanged.
- R10: Decimal adjust (14) adds 06h when the low nibble of A exceeds 9 or AC is set. It adds 60h when A exceeds 99h or C is set. C becomes the old C OR the carry out of bit 7 of that sum. AC is the carry out of bit 3 of that sum. Z, S and P follow R4.
- R11: A clock with `op_valid` low, or with reserved `op_code` 15, changes neither `result_q` nor `flags_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Perform the operation on this clock |
| op_code | input | 4 | Operation select (codes listed in the requirements) |
| acc_in | input | 8 | Accumulator operand A |
| opb_in | input | 8 | Second operand B |
| result_q | output | 8 | Registered result |
| flags_q | output | 5 | Registered flags {S,Z,AC,P,C} |

## Verification
Directed operand pairs are placed at nibble and byte boundaries: 0Fh+01h, FFh+01h, 00h−01h and equal operands. These separate a nibble carry from a byte carry and a borrow from a zero result. Chained sequences with C preset to 1 and to 0 show whether add-with-carry, subtract-with-borrow and the through-carry rotates actually read the stored flag. BCD sums that need a low-only, high-only, both or no correction, with AC or C forced beforehand, test each adjust condition separately. A long stream of random operands and opcodes, including idle and reserved cycles, is compared every clock against a behavioural model. This catches wrong flag hold rules that the directed cases might miss.

// File: rtl/acc_alu_pkg.sv
// Package: shared opcode encoding, flag layout and helper functions
// for the accumulator ALU. Assumes an 8-bit datapath split into two nibbles.
package acc_alu_pkg;

    localparam int ACC_W  = 8;
    localparam int NIB_W  = 4;
    localparam int FLAG_W = 5;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_INC = 4'd4,
        OP_DEC = 4'd5,
        OP_AND = 4'd6,
        OP_OR  = 4'd7,
        OP_XOR = 4'd8,
        OP_CMP = 4'd9,
        OP_ROL = 4'd10,
        OP_ROR = 4'd11,
        OP_RCL = 4'd12,
        OP_RCR = 4'd13,
        OP_DAA = 4'd14,
        OP_NOP = 4'd15
    } alu_op_e;

    // Flag word, MSB first: sign, zero, aux carry, parity, carry.
    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic c;
    } alu_flags_t;

    // Derive the result-dependent flags; caller supplies carry and aux.
    function automatic alu_flags_t mk_flags(input logic [ACC_W-1:0] r,
                                            input logic ac,
                                            input logic c);
        alu_flags_t f;
        f.s  = r[ACC_W-1];
        f.z  = (r == '0);
        f.ac = ac;
        f.p  = ~(^r);
        f.c  = c;
        return f;
    endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
// Module: acc_alu_addsub
// Shared adder/subtractor used by add, subtract, increment, decrement
// and compare. Subtraction adds the inverted operand with inverted
// carry-in; the carry and nibble-carry outputs are returned as borrows
// when is_sub is high. Assumes W is a multiple of NW.
module acc_alu_addsub #(
    parameter int W  = 8,
    parameter int NW = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         is_sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         hcout
);
    logic [W-1:0]  b_eff;
    logic          c_eff;
    logic [W:0]    full;
    logic [NW:0]   low;

    // Operand conditioning for two's complement subtraction.
    always_comb begin
        b_eff = is_sub ? ~b : b;
        c_eff = is_sub ? ~cin : cin;
    end

    // Full-width and low-nibble sums; outputs flipped to borrow sense on subtract.
    always_comb begin
        full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        low   = {1'b0, a[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, c_eff};
        sum   = full[W-1:0];
        cout  = full[W] ^ is_sub;
        hcout = low[NW] ^ is_sub;
    end

endmodule

// File: rtl/acc_alu_bitops.sv
// Module: acc_alu_bitops
// Bitwise operations and the four one-position rotates. Returns the new
// value and the carry bit the operation produces; for bitwise operations
// the carry output is zero. Assumes op is one of AND/OR/XOR/ROL/ROR/RCL/RCR
// when its outputs are used.
module acc_alu_bitops #(
    parameter int W = 8
) (
    input  acc_alu_pkg::alu_op_e op,
    input  logic [W-1:0]         a,
    input  logic [W-1:0]         b,
    input  logic                 cin,
    output logic [W-1:0]         res,
    output logic                 cout
);
    import acc_alu_pkg::*;

    // Select the bitwise or rotate result for the requested operation.
    always_comb begin
        res  = '0;
        cout = 1'b0;
        unique case (op)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_ROL: begin res = {a[W-2:0], a[W-1]}; cout = a[W-1]; end
            OP_ROR: begin res = {a[0], a[W-1:1]};   cout = a[0];   end
            OP_RCL: begin res = {a[W-2:0], cin};    cout = a[W-1]; end
            OP_RCR: begin res = {cin, a[W-1:1]};    cout = a[0];   end
            default: begin res = '0; cout = 1'b0; end
        endcase
    end

endmodule

// File: rtl/acc_alu_decadj.sv
// Module: acc_alu_decadj
// Decimal correction after a packed-BCD addition. The low digit is fixed
// when it is above nine or the aux flag is set; the high digit when the
// whole byte is above 99h or the carry flag is set. Assumes an 8-bit
// operand made of two digits.
module acc_alu_decadj #(
    parameter int W  = 8,
    parameter int NW = 4
) (
    input  logic [W-1:0] a,
    input  logic         ac_in,
    input  logic         c_in,
    output logic [W-1:0] res,
    output logic         c_out,
    output logic         ac_out
);
    localparam logic [NW-1:0] DIGIT_MAX = NW'(9);
    localparam logic [W-1:0]  BYTE_MAX  = W'(8'h99);
    localparam logic [NW-1:0] FIX       = NW'(6);

    logic          fix_lo, fix_hi;
    logic [W-1:0]  adj;
    logic [W:0]    total;
    logic [NW:0]   low;

    // Decide which digits need the +6 correction.
    always_comb begin
        fix_lo = (a[NW-1:0] > DIGIT_MAX) | ac_in;
        fix_hi = (a > BYTE_MAX) | c_in;
        adj    = {(fix_hi ? FIX : {NW{1'b0}}), (fix_lo ? FIX : {NW{1'b0}})};
    end

    // Apply the correction and extract the carries it produces.
    always_comb begin
        total  = {1'b0, a} + {1'b0, adj};
        low    = {1'b0, a[NW-1:0]} + {1'b0, adj[NW-1:0]};
        res    = total[W-1:0];
        c_out  = c_in | total[W];
        ac_out = low[NW];
    end

endmodule

// File: rtl/acc_alu.sv
// Module: acc_alu (top)
// Accumulator ALU: decodes op_code, selects among the add/subtract,
// bitwise/rotate and decimal-adjust units, and registers the result and
// the five flags on each valid clock. Chained operations read carry and
// aux from the flag register. Compare writes flags only; plain and
// through-carry rotates write result and carry only. Synchronous
// active-low reset. Assumes the datapath width from acc_alu_pkg.
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [3:0]         op_code,
    input  logic [ACC_W-1:0]   acc_in,
    input  logic [ACC_W-1:0]   opb_in,
    output logic [ACC_W-1:0]   result_q,
    output logic [FLAG_W-1:0]  flags_q
);
    alu_op_e    op;
    alu_flags_t fl_q, fl_d;
    logic [ACC_W-1:0] res_d;
    logic       wr_res, wr_flg;

    logic [ACC_W-1:0] as_b, as_sum;
    logic       as_cin, as_sub, as_c, as_hc;
    logic [ACC_W-1:0] bo_res;
    logic       bo_c;
    logic [ACC_W-1:0] da_res;
    logic       da_c, da_ac;

    assign op = alu_op_e'(op_code);

    // Operand and mode selection for the shared adder.
    always_comb begin
        as_b   = opb_in;
        as_cin = 1'b0;
        as_sub = 1'b0;
        unique case (op)
            OP_ADC: as_cin = fl_q.c;
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBB: begin as_sub = 1'b1; as_cin = fl_q.c; end
            OP_INC: as_b = ACC_W'(1);
            OP_DEC: begin as_b = ACC_W'(1); as_sub = 1'b1; end
            default: ;
        endcase
    end

    acc_alu_addsub #(.W(ACC_W), .NW(NIB_W)) u_addsub (
        .a      (acc_in),
        .b      (as_b),
        .cin    (as_cin),
        .is_sub (as_sub),
        .sum    (as_sum),
        .cout   (as_c),
        .hcout  (as_hc)
    );

    acc_alu_bitops #(.W(ACC_W)) u_bitops (
        .op   (op),
        .a    (acc_in),
        .b    (opb_in),
        .cin  (fl_q.c),
        .res  (bo_res),
        .cout (bo_c)
    );

    acc_alu_decadj #(.W(ACC_W), .NW(NIB_W)) u_decadj (
        .a      (acc_in),
        .ac_in  (fl_q.ac),
        .c_in   (fl_q.c),
        .res    (da_res),
        .c_out  (da_c),
        .ac_out (da_ac)
    );

    // Per-operation result, flag rules and write enables.
    always_comb begin
        res_d  = result_q;
        fl_d   = fl_q;
        wr_res = 1'b0;
        wr_flg = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                res_d = as_sum; wr_res = 1'b1; wr_flg = 1'b1;
                fl_d  = mk_flags(as_sum, as_hc, as_c);
            end
            OP_INC, OP_DEC: begin
                res_d = as_sum; wr_res = 1'b1; wr_flg = 1'b1;
                fl_d  = mk_flags(as_sum, as_hc, fl_q.c);
            end
            OP_CMP: begin
                wr_flg = 1'b1;
                fl_d   = mk_flags(as_sum, as_hc, as_c);
            end
            OP_AND, OP_OR, OP_XOR: begin
                res_d = bo_res; wr_res = 1'b1; wr_flg = 1'b1;
                fl_d  = mk_flags(bo_res, 1'b0, 1'b0);
            end
            OP_ROL, OP_ROR, OP_RCL, OP_RCR: begin
                res_d  = bo_res; wr_res = 1'b1; wr_flg = 1'b1;
                fl_d   = fl_q;
                fl_d.c = bo_c;
            end
            OP_DAA: begin
                res_d = da_res; wr_res = 1'b1; wr_flg = 1'b1;
                fl_d  = mk_flags(da_res, da_ac, da_c);
            end
            default: ;
        endcase
    end

    // Result register: loads on valid writing operations.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result_q <= '0;
        else if (op_valid && wr_res)
            result_q <= res_d;
    end

    // Flag register: loads on valid operations that define flags.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fl_q <= '0;
        else if (op_valid && wr_flg)
            fl_q <= fl_d;
    end

    assign flags_q = fl_q;

    // R7
    cmp_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd9) |=> $stable(result_q));

    // R5
    incdec_holds_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'd4 || op_code == 4'd5)) |=> (flags_q[0] == $past(flags_q[0])));

    // R6
    logic_clears_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd6 && op_code <= 4'd8) |=> (flags_q[0] == 1'b0 && flags_q[2] == 1'b0));

    // R4
    zero_matches_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code <= 4'd8 || op_code == 4'd14)) |=> (flags_q[3] == (result_q == '0)));

    // R4
    sign_matches_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code <= 4'd8 || op_code == 4'd14)) |=> (flags_q[4] == result_q[ACC_W-1]));

    // R8
    rotate_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd10 && op_code <= 4'd13) |=> $stable(flags_q[4:1]));

    // R11
    idle_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_code == 4'd15) |=> ($stable(result_q) && $stable(flags_q)));

endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [7:0] acc_in = 8'd0;
    logic [7:0] opb_in = 8'd0;
    logic [7:0] result_q;
    logic [4:0] flags_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    int m_res = 0;
    int m_c = 0, m_p = 0, m_ac = 0, m_z = 0, m_s = 0;

    always #2 clk = ~clk;

    acc_alu u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .acc_in(acc_in), .opb_in(opb_in), .result_q(result_q), .flags_q(flags_q)
    );

    function automatic int exp_flags();
        return (m_s << 4) | (m_z << 3) | (m_ac << 2) | (m_p << 1) | m_c;
    endfunction

    function automatic string tag_of(int op);
        case (op)
            0, 1: return "R2";
            2, 3: return "R3";
            4, 5: return "R5";
            6, 7, 8: return "R6";
            9: return "R7";
            10, 11: return "R8";
            12, 13: return "R9";
            14: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic set_zsp(int r);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
        m_z = (r == 0);
        m_s = (r >> 7) & 1;
        m_p = ((ones % 2) == 0);
    endtask

    // Behavioural model of one valid operation.
    task automatic model(int op, int a, int b);
        int t, lo, adj;
        case (op)
            0, 1: begin
                t = (op == 1) ? m_c : 0;
                m_ac = ((a % 16) + (b % 16) + t) > 15;
                m_res = (a + b + t) % 256;
                m_c = (a + b + t) > 255;
                set_zsp(m_res);
            end
            2, 3, 9: begin
                t = (op == 3) ? m_c : 0;
                m_ac = ((a % 16) - (b % 16) - t) < 0;
                m_c = (a - b - t) < 0;
                lo = (a - b - t + 256) % 256;
                set_zsp(lo);
                if (op != 9) m_res = lo;
            end
            4: begin m_ac = (a % 16) == 15; m_res = (a + 1) % 256; set_zsp(m_res); end
            5: begin m_ac = (a % 16) == 0;  m_res = (a + 255) % 256; set_zsp(m_res); end
            6: begin m_res = a & b; m_c = 0; m_ac = 0; set_zsp(m_res); end
            7: begin m_res = a | b; m_c = 0; m_ac = 0; set_zsp(m_res); end
            8: begin m_res = a ^ b; m_c = 0; m_ac = 0; set_zsp(m_res); end
            10: begin m_c = a / 128; m_res = ((a * 2) % 256) + m_c; end
            11: begin m_c = a % 2; m_res = (a / 2) + 128 * m_c; end
            12: begin t = m_c; m_c = a / 128; m_res = ((a * 2) % 256) + t; end
            13: begin t = m_c; m_c = a % 2; m_res = (a / 2) + 128 * t; end
            14: begin
                adj = 0;
                if ((a % 16) > 9 || m_ac) adj += 6;
                if (a > 153 || m_c) adj += 96;
                m_ac = ((a % 16) + (adj % 16)) > 15;
                if (a + adj > 255) m_c = 1;
                m_res = (a + adj) % 256;
                set_zsp(m_res);
            end
            default: ;
        endcase
    endtask

    task automatic compare(string tag);
        checks++;
        if (result_q !== 8'(m_res) || flags_q !== 5'(exp_flags())) begin
            errors++;
            $display("FAIL %s: result=%02h flags=%05b expected result=%02h flags=%05b",
                     tag, result_q, flags_q, 8'(m_res), 5'(exp_flags()));
        end
    endtask

    // Drive one cycle (valid or not) and check after the capturing edge.
    task automatic step(bit v, int op, int a, int b, string tag);
        @(negedge clk);
        op_valid = v; op_code = 4'(op); acc_in = 8'(a); opb_in = 8'(b);
        @(negedge clk);
        op_valid = 1'b0;
        if (v) model(op, a, b);
        compare(tag);
    endtask

    task automatic run(int op, int a, int b);
        step(1'b1, op, a, b, tag_of(op));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        compare("R1");

        // R2 add boundaries
        run(0, 8'h0F, 8'h01);
        run(0, 8'hFF, 8'h01);
        run(1, 8'h10, 8'h20);          // uses carry=1 from previous
        run(0, 8'h59, 8'h69);
        // R3 subtract boundaries
        run(2, 8'h00, 8'h01);
        run(3, 8'h10, 8'h0F);          // borrow in = 1
        run(2, 8'h44, 8'h44);
        // R5 inc/dec hold carry
        run(2, 8'h00, 8'h01);          // sets C
        run(4, 8'hFF, 8'h00);
        run(5, 8'h00, 8'h00);
        run(5, 8'h10, 8'h00);
        // R6 logic
        run(0, 8'hFF, 8'h01);
        run(6, 8'hF0, 8'h3C);
        run(7, 8'h00, 8'h00);
        run(8, 8'hAA, 8'h55);
        // R7 compare greater, less, equal
        run(9, 8'h50, 8'h20);
        run(9, 8'h20, 8'h50);
        run(9, 8'h33, 8'h33);
        // R8 plain rotates
        run(10, 8'h81, 8'h00);
        run(11, 8'h01, 8'h00);
        run(11, 8'h02, 8'h00);
        // R9 through-carry rotates
        run(2, 8'h00, 8'h01);
        run(12, 8'h40, 8'h00);
        run(13, 8'h01, 8'h00);
        run(13, 8'h00, 8'h00);
        // R10 decimal adjust cases
        run(0, 8'h45, 8'h27); run(14, 8'h6C, 8'h00);
        run(0, 8'h76, 8'h62); run(14, 8'hD8, 8'h00);
        run(0, 8'h89, 8'h72); run(14, 8'hFB, 8'h00);
        run(0, 8'h09, 8'h08); run(14, 8'h11, 8'h00);    // AC set
        run(0, 8'h90, 8'h90); run(14, 8'h20, 8'h00);    // C set
        run(0, 8'h45, 8'h22); run(14, 8'h67, 8'h00);    // no fix
        run(14, 8'h9A, 8'h00);
        // R11 idle and reserved opcode
        step(1'b0, 0, 8'h12, 8'h34, "R11");
        step(1'b1, 15, 8'h12, 8'h34, "R11");

        // random stream with idles
        for (int i = 0; i < 3000; i++) begin
            int op = $urandom_range(0, 15);
            bit v  = ($urandom_range(0, 7) != 0);
            step(v, op, $urandom_range(0, 255), $urandom_range(0, 255),
                 v ? tag_of(op) : "R11");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule